// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a CPU segmented address onto a 24-bit physical address. It holds a table of 64 segment descriptors. Each descriptor carries a 16-bit base, an 8-bit limit and an 8-bit attribute byte. On the translation side, a segment number and a 16-bit offset go in and a physical address comes out in the same cycle. The low offset byte passes through untouched. The upper 16 address bits are the sum of the segment base and the upper offset byte.

Software fills the table through a byte-wide register port. The port has a synchronous write strobe and a combinational read, both addressed by an 8-bit port number. A segment pointer selects the descriptor to access. A 2-bit byte counter selects a field within that descriptor. Several port numbers step the counter, the pointer or both after a write, so a whole table can be streamed in with one port number. Limit and attribute bytes are only stored; no checking is done on them. The mode register is likewise only held.

Both sides are plain signals. The translation path is purely combinational. A register write is taken on any rising edge with the strobe high, so neither side has back-pressure and neither needs a ready signal.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every descriptor base, limit and attribute is zero. The segment pointer, byte counter and mode register are also zero, so reads of any decoded port return 0 and the physical address equals the offset.
- R2: phys_addr[7:0] always equals offset[7:0].
- R3: phys_addr[23:8] equals the selected base plus offset[15:8] zero-extended to 16 bits, modulo 2^16.
- R4: Only seg_num[5:0] selects a descriptor. seg_num[6] has no effect on phys_addr.
- R5: A write to port 0x00 loads the mode register, which reads back on port 0x00. A write to port 0x01 loads the pointer with data[5:0] and clears the counter; the pointer reads back on port 0x01 as {2'b00, pointer}. A write to port 0x20 loads the counter with data[1:0]; it reads back on port 0x20 as {6'b0, counter}.
- R6: The field codes are 0 = base bits [15:8], 1 = base bits [7:0], 2 = limit, 3 = attribute. Reads always use the descriptor at the pointer and have no side effect. Ports 0x0B and 0x0F read the field given by the counter. Ports 0x08 and 0x0C read the base byte given by counter bit 0. Ports 0x09 and 0x0D read the limit. Ports 0x0A and 0x0E read the attribute.
- R7: A write to port 0x08 stores the base byte selected by counter bit 0, then advances the counter modulo 4. The pointer is unchanged.
- R8: Writes to port 0x09 (limit) and port 0x0A (attribute) store the field and leave the pointer and counter unchanged.
- R9: Writes to ports 0x0C, 0x0D and 0x0E store, respectively, the base byte selected by counter bit 0, the limit and the attribute. Each then advances the pointer modulo 64, and the counter is unchanged.
- R10: A write to port 0x0B stores the field given by the counter and advances the counter modulo 4. The pointer is unchanged.
- R11: A write to port 0x0F stores the field given by the counter and advances the counter modulo 4. When the counter wraps from 3 to 0, the pointer also advances modulo 64.
- R12: Writes to any other port number change no state. Reads of any other port number return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_port | input | 8 | Register port number for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_port |
| seg_num | input | 7 | Segment number to translate |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 24 | Translated physical address |

## Verification
Assertions in the controller check the pointer and counter on every cycle. They cover the clear on a pointer load, the counter step of the base port, the hold on the plain limit and attribute ports, the pointer step of the auto-increment ports, the combined stepping of the streaming port, and the hold on undecoded writes. An assertion in the table checks that each write lands in the addressed byte. Only the bench scenarios can show the following:
- the zeroed table after reset;
- the field order seen through each read port;
- the discarded carry at the top of the adder;
- the ignored segment bit 6;
- the 0xFF read of undecoded ports.

The bench shows these by comparing against its own model on every clock.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLD_BASE_HI = 2'd0,
    FLD_BASE_LO = 2'd1,
    FLD_LIMIT   = 2'd2,
    FLD_ATTR    = 2'd3
  } field_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_MODE,
    OP_SEL,
    OP_CNT,
    OP_BASE,
    OP_LIM,
    OP_ATT,
    OP_ALL,
    OP_BASE_INC,
    OP_LIM_INC,
    OP_ATT_INC,
    OP_STREAM
  } reg_op_e;

  localparam logic [7:0] PORT_MODE     = 8'h00;
  localparam logic [7:0] PORT_SEL      = 8'h01;
  localparam logic [7:0] PORT_BASE     = 8'h08;
  localparam logic [7:0] PORT_LIM      = 8'h09;
  localparam logic [7:0] PORT_ATT      = 8'h0A;
  localparam logic [7:0] PORT_ALL      = 8'h0B;
  localparam logic [7:0] PORT_BASE_INC = 8'h0C;
  localparam logic [7:0] PORT_LIM_INC  = 8'h0D;
  localparam logic [7:0] PORT_ATT_INC  = 8'h0E;
  localparam logic [7:0] PORT_STREAM   = 8'h0F;
  localparam logic [7:0] PORT_CNT      = 8'h20;

  localparam logic [7:0] UNDECODED_READ = 8'hFF;

  function automatic reg_op_e decode_port(input logic [7:0] port);
    reg_op_e op;
    case (port)
      PORT_MODE:     op = OP_MODE;
      PORT_SEL:      op = OP_SEL;
      PORT_CNT:      op = OP_CNT;
      PORT_BASE:     op = OP_BASE;
      PORT_LIM:      op = OP_LIM;
      PORT_ATT:      op = OP_ATT;
      PORT_ALL:      op = OP_ALL;
      PORT_BASE_INC: op = OP_BASE_INC;
      PORT_LIM_INC:  op = OP_LIM_INC;
      PORT_ATT_INC:  op = OP_ATT_INC;
      PORT_STREAM:   op = OP_STREAM;
      default:       op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 64,
  parameter int BASE_W  = 16,
  localparam int IDX_W  = $clog2(SEG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  acc_idx,
  input  field_e            acc_fld,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [IDX_W-1:0]  xl_idx,
  output logic [BASE_W-1:0] xl_base
);

  logic [BASE_W-1:0] base_q [SEG_CNT];
  logic [7:0]        lim_q  [SEG_CNT];
  logic [7:0]        att_q  [SEG_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_CNT; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        att_q[i]  <= '0;
      end
    end else if (wr_en) begin
      case (acc_fld)
        FLD_BASE_HI: base_q[acc_idx][BASE_W-1 -: 8] <= wr_data;
        FLD_BASE_LO: base_q[acc_idx][7:0]           <= wr_data;
        FLD_LIMIT:   lim_q[acc_idx]                 <= wr_data;
        default:     att_q[acc_idx]                 <= wr_data;
      endcase
    end
  end

  always_comb begin
    case (acc_fld)
      FLD_BASE_HI: rd_data = base_q[acc_idx][BASE_W-1 -: 8];
      FLD_BASE_LO: rd_data = base_q[acc_idx][7:0];
      FLD_LIMIT:   rd_data = lim_q[acc_idx];
      default:     rd_data = att_q[acc_idx];
    endcase
  end

  assign xl_base = base_q[xl_idx];

  // Write landing check: the byte addressed by the last write holds its data.
  logic             chk_vld;
  logic [IDX_W-1:0] chk_idx;
  field_e           chk_fld;
  logic [7:0]       chk_data;
  logic [7:0]       chk_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_idx  <= '0;
      chk_fld  <= FLD_BASE_HI;
      chk_data <= '0;
    end else begin
      chk_vld  <= wr_en;
      chk_idx  <= acc_idx;
      chk_fld  <= acc_fld;
      chk_data <= wr_data;
    end
  end

  always_comb begin
    case (chk_fld)
      FLD_BASE_HI: chk_byte = base_q[chk_idx][BASE_W-1 -: 8];
      FLD_BASE_LO: chk_byte = base_q[chk_idx][7:0];
      FLD_LIMIT:   chk_byte = lim_q[chk_idx];
      default:     chk_byte = att_q[chk_idx];
    endcase
  end

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> chk_byte == chk_data);

endmodule

// File: rtl/seg_reg_ctrl.sv
module seg_reg_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 64,
  localparam int IDX_W  = $clog2(SEG_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_port,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output field_e           tbl_fld,
  output logic [7:0]       tbl_wdata,
  input  logic [7:0]       tbl_rdata
);

  logic [IDX_W-1:0] sar_q;
  logic [1:0]       dsc_q;
  logic [7:0]       mode_q;
  reg_op_e          op;
  logic             fld_access;

  assign op = decode_port(reg_port);

  always_comb begin
    fld_access = 1'b1;
    case (op)
      OP_BASE, OP_BASE_INC: tbl_fld = field_e'({1'b0, dsc_q[0]});
      OP_LIM, OP_LIM_INC:   tbl_fld = FLD_LIMIT;
      OP_ATT, OP_ATT_INC:   tbl_fld = FLD_ATTR;
      OP_ALL, OP_STREAM:    tbl_fld = field_e'(dsc_q);
      default: begin
        tbl_fld    = FLD_BASE_HI;
        fld_access = 1'b0;
      end
    endcase
  end

  assign tbl_we    = reg_we && fld_access;
  assign tbl_idx   = sar_q;
  assign tbl_wdata = reg_wdata;

  always_comb begin
    case (op)
      OP_MODE: reg_rdata = mode_q;
      OP_SEL:  reg_rdata = 8'(sar_q);
      OP_CNT:  reg_rdata = 8'(dsc_q);
      OP_NONE: reg_rdata = UNDECODED_READ;
      default: reg_rdata = tbl_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      dsc_q  <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      case (op)
        OP_MODE: mode_q <= reg_wdata;
        OP_SEL: begin
          sar_q <= reg_wdata[IDX_W-1:0];
          dsc_q <= '0;
        end
        OP_CNT:            dsc_q <= reg_wdata[1:0];
        OP_BASE, OP_ALL:   dsc_q <= dsc_q + 2'd1;
        OP_BASE_INC, OP_LIM_INC, OP_ATT_INC:
                           sar_q <= sar_q + IDX_W'(1);
        OP_STREAM: begin
          dsc_q <= dsc_q + 2'd1;
          if (dsc_q == 2'd3) sar_q <= sar_q + IDX_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R5: pointer load clears the counter
  a_r5_sel_clears_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && op == OP_SEL) |=> (dsc_q == 2'd0 && sar_q == $past(reg_wdata[IDX_W-1:0])));

  a_r7_base_steps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && op == OP_BASE) |=> (dsc_q == $past(dsc_q) + 2'd1 && $stable(sar_q)));

  a_r8_fixed_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (op == OP_LIM || op == OP_ATT)) |=> ($stable(sar_q) && $stable(dsc_q)));

  a_r9_ptr_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (op == OP_BASE_INC || op == OP_LIM_INC || op == OP_ATT_INC))
      |=> (sar_q == $past(sar_q) + IDX_W'(1) && $stable(dsc_q)));

  a_r10_all_steps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && op == OP_ALL) |=> (dsc_q == $past(dsc_q) + 2'd1 && $stable(sar_q)));

  a_r11_stream_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && op == OP_STREAM) |=> (dsc_q == $past(dsc_q) + 2'd1 &&
      sar_q == (($past(dsc_q) == 2'd3) ? $past(sar_q) + IDX_W'(1) : $past(sar_q))));

  a_r12_undecoded_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && op == OP_NONE) |=> ($stable(sar_q) && $stable(dsc_q) && $stable(mode_q)));

  a_r12_no_table_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE || op == OP_MODE || op == OP_SEL || op == OP_CNT) |-> !tbl_we);

endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int OFF_W  = 16,
  parameter int BASE_W = 16,
  localparam int HI_W  = OFF_W - 8,
  localparam int PA_W  = BASE_W + 8
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [PA_W-1:0]   phys_addr
);

  logic [BASE_W-1:0] upper;

  assign upper     = base + BASE_W'(offset[OFF_W-1 -: HI_W]);
  assign phys_addr = {upper, offset[7:0]};

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT  = 64,
  parameter int SEG_IN_W = 7,
  parameter int OFF_W    = 16,
  parameter int BASE_W   = 16,
  localparam int IDX_W   = $clog2(SEG_CNT),
  localparam int PA_W    = BASE_W + 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [7:0]          reg_port,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [SEG_IN_W-1:0] seg_num,
  input  logic [OFF_W-1:0]    offset,
  output logic [PA_W-1:0]     phys_addr
);

  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  field_e           tbl_fld;
  logic [7:0]       tbl_wdata;
  logic [7:0]       tbl_rdata;
  logic [IDX_W-1:0] xl_idx;
  logic [BASE_W-1:0] xl_base;

  // Segment number reduced modulo the table size (R4)
  assign xl_idx = IDX_W'(seg_num % SEG_CNT);

  seg_reg_ctrl #(.SEG_CNT(SEG_CNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_port  (reg_port),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tbl_we    (tbl_we),
    .tbl_idx   (tbl_idx),
    .tbl_fld   (tbl_fld),
    .tbl_wdata (tbl_wdata),
    .tbl_rdata (tbl_rdata)
  );

  seg_desc_table #(.SEG_CNT(SEG_CNT), .BASE_W(BASE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .acc_idx (tbl_idx),
    .acc_fld (tbl_fld),
    .wr_data (tbl_wdata),
    .rd_data (tbl_rdata),
    .xl_idx  (xl_idx),
    .xl_base (xl_base)
  );

  seg_addr_adder #(.OFF_W(OFF_W), .BASE_W(BASE_W)) u_adder (
    .base      (xl_base),
    .offset    (offset),
    .phys_addr (phys_addr)
  );

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_port;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [6:0]  seg_num;
  logic [15:0] offset;
  logic [23:0] phys_addr;

  always #4 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_num(seg_num),
    .offset(offset), .phys_addr(phys_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference model
  int m_base [64];
  int m_lim  [64];
  int m_att  [64];
  int m_sar, m_dsc, m_mode;

  function automatic int m_field(int f);
    case (f & 3)
      0: return (m_base[m_sar] >> 8) & 255;
      1: return m_base[m_sar] & 255;
      2: return m_lim[m_sar];
      default: return m_att[m_sar];
    endcase
  endfunction

  function automatic int m_read(int p);
    case (p)
      'h00: return m_mode;
      'h01: return m_sar;
      'h20: return m_dsc;
      'h08, 'h0C: return m_field(m_dsc & 1);
      'h09, 'h0D: return m_field(2);
      'h0A, 'h0E: return m_field(3);
      'h0B, 'h0F: return m_field(m_dsc);
      default: return 255;
    endcase
  endfunction

  task automatic m_put(int f, int d);
    case (f & 3)
      0: m_base[m_sar] = (d << 8) | (m_base[m_sar] & 255);
      1: m_base[m_sar] = (m_base[m_sar] & 'hFF00) | d;
      2: m_lim[m_sar] = d;
      default: m_att[m_sar] = d;
    endcase
  endtask

  task automatic m_write(int p, int d);
    case (p)
      'h00: m_mode = d;
      'h01: begin m_sar = d & 63; m_dsc = 0; end
      'h20: m_dsc = d & 3;
      'h08: begin m_put(m_dsc & 1, d); m_dsc = (m_dsc + 1) & 3; end
      'h09: m_put(2, d);
      'h0A: m_put(3, d);
      'h0B: begin m_put(m_dsc, d); m_dsc = (m_dsc + 1) & 3; end
      'h0C: begin m_put(m_dsc & 1, d); m_sar = (m_sar + 1) & 63; end
      'h0D: begin m_put(2, d); m_sar = (m_sar + 1) & 63; end
      'h0E: begin m_put(3, d); m_sar = (m_sar + 1) & 63; end
      'h0F: begin
        m_put(m_dsc, d);
        m_dsc = (m_dsc + 1) & 3;
        if (m_dsc == 0) m_sar = (m_sar + 1) & 63;
      end
      default: ;
    endcase
  endtask

  function automatic int m_phys(int seg, int off);
    return (((m_base[seg & 63] + (off >> 8)) & 'hFFFF) << 8) | (off & 255);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare mid-cycle, update model at posedge
  task automatic step(bit we, int p, int d, int seg, int off, string tag);
    @(negedge clk);
    reg_we = we; reg_port = 8'(p); reg_wdata = 8'(d);
    seg_num = 7'(seg); offset = 16'(off);
    #1;
    check(tag, int'(reg_rdata), m_read(p & 255));
    check({tag, " R2"}, int'(phys_addr[7:0]), off & 255);
    check({tag, " R3"}, int'(phys_addr), m_phys(seg & 127, off & 'hFFFF));
    @(posedge clk);
    if (we) m_write(p & 255, d & 255);
  endtask

  task automatic wr(int p, int d, string tag);
    step(1'b1, p, d, 5, 'h1234, tag);
  endtask

  task automatic rd(int p, string tag);
    step(1'b0, p, 0, 5, 'h1234, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lfsr;
    int ports [16];
    ports = '{'h00, 'h01, 'h20, 'h08, 'h09, 'h0A, 'h0B, 'h0C,
              'h0D, 'h0E, 'h0F, 'h0F, 'h02, 'h10, 'h21, 'hFF};
    for (int i = 0; i < 64; i++) begin m_base[i] = 0; m_lim[i] = 0; m_att[i] = 0; end
    m_sar = 0; m_dsc = 0; m_mode = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_port = '0; reg_wdata = '0; seg_num = '0; offset = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    foreach (ports[k]) rd(ports[k], "R1");
    for (int s = 0; s < 128; s += 19) step(1'b0, 'h0B, 0, s, s * 517, "R1");

    // R5: mode, pointer and counter loads
    wr('h00, 'hA5, "R5"); rd('h00, "R5");
    wr('h20, 'hFE, "R5"); rd('h20, "R5");
    wr('h01, 'hFF, "R5"); rd('h01, "R5"); rd('h20, "R5");

    // R11: stream across the pointer wrap
    wr('h01, 62, "R11");
    for (int i = 0; i < 12; i++) wr('h0F, i * 17 + 3, "R11");
    rd('h01, "R11"); rd('h20, "R11");

    // R6: field order through every read port
    wr('h01, 62, "R6");
    for (int f = 0; f < 4; f++) begin
      wr('h20, f, "R6");
      rd('h0B, "R6"); rd('h0F, "R6"); rd('h08, "R6"); rd('h0C, "R6");
      rd('h09, "R6"); rd('h0D, "R6"); rd('h0A, "R6"); rd('h0E, "R6");
    end

    // R7: base port steps the counter
    wr('h01, 10, "R7");
    wr('h08, 'hAB, "R7"); wr('h08, 'hCD, "R7"); rd('h20, "R7"); rd('h01, "R7");
    wr('h08, 'h11, "R7"); wr('h20, 0, "R7"); rd('h0B, "R7");

    // R8: limit and attribute hold pointer and counter
    wr('h20, 3, "R8");
    wr('h09, 'h44, "R8"); wr('h0A, 'h55, "R8");
    rd('h01, "R8"); rd('h20, "R8"); rd('h09, "R8"); rd('h0A, "R8");

    // R9: auto-increment ports, with pointer wrap
    wr('h01, 63, "R9"); wr('h20, 1, "R9");
    wr('h0C, 'h77, "R9"); rd('h01, "R9");
    wr('h0D, 'h88, "R9"); wr('h0E, 'h99, "R9");
    rd('h01, "R9"); rd('h20, "R9");
    wr('h01, 63, "R9"); rd('h08, "R9");

    // R10: all-field port without pointer movement
    wr('h01, 20, "R10"); wr('h20, 3, "R10");
    for (int i = 0; i < 5; i++) wr('h0B, 'h30 + i, "R10");
    rd('h01, "R10"); rd('h20, "R10");

    // R12: undecoded ports
    for (int i = 0; i < 7; i++) begin
      int p;
      p = (i == 0) ? 'h02 : (i == 1) ? 'h07 : (i == 2) ? 'h10 : (i == 3) ? 'h1F :
          (i == 4) ? 'h21 : (i == 5) ? 'h80 : 'hFF;
      wr(p, 'h3C, "R12"); rd(p, "R12");
    end
    rd('h00, "R12"); rd('h01, "R12"); rd('h20, "R12"); rd('h0B, "R12");

    // R3 / R4: carry discard and ignored segment bit 6
    wr('h01, 5, "R3"); wr('h0F, 'hFF, "R3"); wr('h0F, 'hFF, "R3");
    step(1'b0, 'h0B, 0, 5, 'hFF80, "R3");
    step(1'b0, 'h0B, 0, 'h45, 'hFF80, "R4");
    step(1'b0, 'h0B, 0, 'h40, 'h0102, "R4");
    step(1'b0, 'h0B, 0, 'h4A, 'h8001, "R4");

    // Mixed traffic
    lfsr = 'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 'hFFFF;
      step(lfsr[0], ports[(lfsr >> 1) & 15], (lfsr >> 5) & 255, (lfsr >> 3) & 127,
           (lfsr * 40503) & 'hFFFF, "R6");
    end

    summary();
    $finish;
  end

endmodule